// File: doc/BRIEF.md
# LIN Header Transmitter with Bit Monitor

This block sends the header that opens a LIN frame. A one-cycle trigger pulse starts a sequence on the serial output, and the sequence is paced by an oversampling baud tick. The sequence begins with a dominant (low) break whose length is programmable. One recessive delimiter bit follows the break. Depending on a 2-bit header selector, the sequence can then add the sync byte and a protected identifier byte. The block computes the two parity bits of the identifier itself. The header settings are captured when the trigger is accepted, so software can change them while a header is going out.

While the header is on the line, the block reads the bus back and compares it with the level it is driving. The comparison happens once per bit, in the middle of the bit. If bit-error checking is enabled and the two levels differ, a sticky error flag is set. A second sticky flag reports that a header has finished. Each flag is cleared by its own write-one pulse.

Top module: `lin_header_tx`

## Requirements
- R1: During and after reset, `txOut` is 1, and `busy`, `hdrDone` and `bitErr` are 0.
- R2: A `trigSet` pulse sampled while the block is idle makes `busy` 1 and `txOut` 0 in the next cycle.
- R3: One bit time is OVS baud ticks (16 by default), counted only on clock edges where `baudTick` is 1. The break holds `txOut` at 0 for `brkCnt` + 8 bit times. Exactly one high delimiter bit follows it.
- R4: `hdrSel` selects what follows the delimiter. The value 0 adds nothing. The value 1 adds the sync frame. The values 2 and 3 add the sync frame and then the identifier frame.
- R5: The sync frame has one low start bit, then the byte 0x55 sent least significant bit first, then one high stop bit.
- R6: The identifier frame uses the same framing, with byte {P1, P0, ident[5:0]}. Here P0 = ident[0]^ident[1]^ident[2]^ident[4] and P1 = ~(ident[1]^ident[3]^ident[4]^ident[5]).
- R7: `busy` falls at the end of the last bit of the selected header. The header then lasts exactly OVS × (number of bits) ticks. In the same cycle `hdrDone` becomes 1 and stays 1. `txOut` stays 1 while the block is idle.
- R8: A `trigSet` pulse while `busy` is 1 is ignored, and it is not queued. Changes to `hdrSel`, `brkCnt` or `ident` during a header do not alter that header.
- R9: When `bitErrEn` is 1 and `lineIn` differs from `txOut` at the middle sample of a bit, `bitErr` becomes 1 and stays 1. The middle sample is the tick that moves the tick count within the bit from OVS/2-1 to OVS/2.
- R10: `bitErr` stays 0 in three cases: a mismatch that does not cover the middle sample, any mismatch while `bitErrEn` is 0, and any mismatch while the block is idle.
- R11: A `doneClr` pulse clears `hdrDone`, and an `errClr` pulse clears `bitErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigSet | input | 1 | Start pulse for a header |
| hdrSel | input | 2 | Header content selector |
| brkCnt | input | BCNT_W | Extra break bits beyond 8 |
| ident | input | 6 | Identifier bits ID0..ID5 |
| bitErrEn | input | 1 | Enables the read-back comparison |
| baudTick | input | 1 | Oversampling tick, OVS per bit |
| lineIn | input | 1 | Bus level read back |
| doneClr | input | 1 | Write-one clear of hdrDone |
| errClr | input | 1 | Write-one clear of bitErr |
| txOut | output | 1 | Serial line drive |
| busy | output | 1 | Trigger enable, clears itself when the header ends |
| hdrDone | output | 1 | Sticky header-finished flag |
| bitErr | output | 1 | Sticky bit-error flag |

## Verification
The hardest case to reach from the ports is a mismatch between the driven and the read-back level that lands inside a bit but away from its middle sample. Only the sample position separates it from a real bit error. The bench drives `lineIn` as `txOut` XOR a corruption signal that it controls tick by tick. It opens the corruption window either across a whole chosen bit or only over ticks 1 to 3 of that bit, so the same stimulus tests both the setting of the flag and the ignoring of a glitch. A mid-header retrigger that also changes every header field checks that the captured settings hold for the whole header.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  localparam int ID_W = 6;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [1:0] SEL_BREAK = 2'd0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DELIM,
    ST_SYNC,
    ST_PID
  } hdr_state_e;

  // strobes from sequencer to datapath, at most one line action per cycle
  typedef struct packed {
    logic capture;
    logic holdLow;
    logic holdHigh;
    logic loadSync;
    logic loadPid;
    logic shiftOut;
    logic midSample;
    logic finish;
  } hdr_strobe_t;

  function automatic logic [7:0] pidOf(input logic [ID_W-1:0] id);
    logic p0;
    logic p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

endpackage

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
  import lin_hdr_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int BRK_BASE = 8,
  parameter int BCNT_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigSet,
  input  logic [1:0]        hdrSel,
  input  logic [BCNT_W-1:0] brkCnt,
  input  logic              baudTick,
  output logic              busy,
  output hdr_strobe_t       stb
);

  localparam int BRK_MAX    = BRK_BASE + (1 << BCNT_W) - 1;
  localparam int FRAME_LAST = 9;
  localparam int CNT_TOP    = (BRK_MAX > FRAME_LAST) ? BRK_MAX : FRAME_LAST;
  localparam int CNT_W      = $clog2(CNT_TOP + 1);
  localparam int TCK_W      = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [TCK_W-1:0] TCK_LAST = TCK_W'(OVS - 1);
  localparam logic [TCK_W-1:0] TCK_MID  = TCK_W'(OVS / 2 - 1);

  hdr_state_e       state, nxtState;
  logic [CNT_W-1:0] bitCnt, nxtCnt;
  logic [TCK_W-1:0] tickCnt;
  logic [1:0]       selLat;
  logic             bitEnd;
  logic             lastBit;

  assign busy    = (state != ST_IDLE);
  assign bitEnd  = busy && baudTick && (tickCnt == TCK_LAST);
  assign lastBit = (bitCnt == '0);

  always_comb begin
    stb           = '0;
    nxtState      = state;
    nxtCnt        = bitCnt;
    stb.midSample = busy && baudTick && (tickCnt == TCK_MID);
    unique case (state)
      ST_IDLE: begin
        if (trigSet) begin
          stb.capture = 1'b1;
          stb.holdLow = 1'b1;
          nxtState    = ST_BRK;
          nxtCnt      = CNT_W'(brkCnt) + CNT_W'(BRK_BASE - 1);
        end
      end
      ST_BRK: begin
        if (bitEnd) begin
          if (lastBit) begin
            stb.holdHigh = 1'b1;
            nxtState     = ST_DELIM;
          end else begin
            nxtCnt = bitCnt - 1'b1;
          end
        end
      end
      ST_DELIM: begin
        if (bitEnd) begin
          if (selLat == SEL_BREAK) begin
            stb.finish = 1'b1;
            nxtState   = ST_IDLE;
          end else begin
            stb.loadSync = 1'b1;
            nxtState     = ST_SYNC;
            nxtCnt       = CNT_W'(FRAME_LAST);
          end
        end
      end
      ST_SYNC, ST_PID: begin
        if (bitEnd) begin
          if (!lastBit) begin
            stb.shiftOut = 1'b1;
            nxtCnt       = bitCnt - 1'b1;
          end else if (state == ST_SYNC && selLat[1]) begin
            stb.loadPid = 1'b1;
            nxtState    = ST_PID;
            nxtCnt      = CNT_W'(FRAME_LAST);
          end else begin
            stb.finish = 1'b1;
            nxtState   = ST_IDLE;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      tickCnt <= '0;
      selLat  <= '0;
    end else begin
      state  <= nxtState;
      bitCnt <= nxtCnt;
      if (stb.capture) begin
        tickCnt <= '0;
        selLat  <= hdrSel;
      end else if (busy && baudTick) begin
        tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
      end
    end
  end

  AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rstN)
    busy && !baudTick |=> busy); // R3

  AST_ONE_LINE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.holdLow, stb.holdHigh, stb.loadSync, stb.loadPid, stb.shiftOut})); // R4

endmodule

// File: rtl/lin_hdr_dp.sv
module lin_hdr_dp
  import lin_hdr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  hdr_strobe_t     stb,
  input  logic [ID_W-1:0] ident,
  input  logic            bitErrEn,
  input  logic            lineIn,
  input  logic            doneClr,
  input  logic            errClr,
  output logic            txOut,
  output logic            hdrDone,
  output logic            bitErr
);

  localparam int FR_W = 9;

  logic [ID_W-1:0] idLat;
  logic [FR_W-1:0] frameSh;
  logic [7:0]      pidByte;
  logic            txBit;
  logic            doneQ;
  logic            errQ;

  assign pidByte = pidOf(idLat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idLat   <= '0;
      frameSh <= '1;
      txBit   <= 1'b1;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (stb.capture) idLat <= ident;

      if (stb.holdLow) begin
        txBit <= 1'b0;
      end else if (stb.holdHigh || stb.finish) begin
        txBit <= 1'b1;
      end else if (stb.loadSync) begin
        txBit   <= 1'b0;
        frameSh <= {1'b1, SYNC_BYTE};
      end else if (stb.loadPid) begin
        txBit   <= 1'b0;
        frameSh <= {1'b1, pidByte};
      end else if (stb.shiftOut) begin
        txBit   <= frameSh[0];
        frameSh <= {1'b1, frameSh[FR_W-1:1]};
      end

      if (stb.finish)       doneQ <= 1'b1;
      else if (doneClr)     doneQ <= 1'b0;

      if (stb.midSample && bitErrEn && (lineIn != txBit)) errQ <= 1'b1;
      else if (errClr)                                     errQ <= 1'b0;
    end
  end

  assign txOut   = txBit;
  assign hdrDone = doneQ;
  assign bitErr  = errQ;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    bitErr && !errClr |=> bitErr); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hdrDone && !doneClr |=> hdrDone); // R7

endmodule

// File: rtl/lin_header_tx.sv
module lin_header_tx
  import lin_hdr_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int BRK_BASE = 8,
  parameter int BCNT_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigSet,
  input  logic [1:0]        hdrSel,
  input  logic [BCNT_W-1:0] brkCnt,
  input  logic [5:0]        ident,
  input  logic              bitErrEn,
  input  logic              baudTick,
  input  logic              lineIn,
  input  logic              doneClr,
  input  logic              errClr,
  output logic              txOut,
  output logic              busy,
  output logic              hdrDone,
  output logic              bitErr
);

  hdr_strobe_t stb;

  lin_hdr_ctrl #(
    .OVS     (OVS),
    .BRK_BASE(BRK_BASE),
    .BCNT_W  (BCNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigSet (trigSet),
    .hdrSel  (hdrSel),
    .brkCnt  (brkCnt),
    .baudTick(baudTick),
    .busy    (busy),
    .stb     (stb)
  );

  lin_hdr_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .ident   (ident),
    .bitErrEn(bitErrEn),
    .lineIn  (lineIn),
    .doneClr (doneClr),
    .errClr  (errClr),
    .txOut   (txOut),
    .hdrDone (hdrDone),
    .bitErr  (bitErr)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut); // R7

  AST_BRK_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txOut); // R2

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> hdrDone); // R7

  AST_ERR_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitErr) |-> $past(busy)); // R10

endmodule

// File: tb/sim_lin_header_tx.sv
`timescale 1ns / 1ps
module sim_lin_header_tx;

  logic       clk = 1'b0;
  logic       rstN;
  logic       trigSet, bitErrEn, baudTick, doneClr, errClr, corrupt;
  logic [1:0] hdrSel;
  logic [2:0] brkCnt;
  logic [5:0] ident;
  logic       lineIn, txOut, busy, hdrDone, bitErr;
  int         nRun = 0;
  int         nFail = 0;
  int         cycCount = 0;

  always #2.5 clk = ~clk;

  assign lineIn = txOut ^ corrupt;

  lin_header_tx u0 (
    .clk(clk), .rstN(rstN), .trigSet(trigSet), .hdrSel(hdrSel), .brkCnt(brkCnt),
    .ident(ident), .bitErrEn(bitErrEn), .baudTick(baudTick), .lineIn(lineIn),
    .doneClr(doneClr), .errClr(errClr), .txOut(txOut), .busy(busy),
    .hdrDone(hdrDone), .bitErr(bitErr)
  );

  // {hdrSel, brkCnt, ident, expected identifier byte}
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 3'd0, 6'h00, 8'h80},
    {2'd1, 3'd7, 6'h00, 8'h80},
    {2'd2, 3'd3, 6'h3C, 8'h3C},
    {2'd3, 3'd5, 6'h01, 8'hC1},
    {2'd2, 3'd1, 6'h3F, 8'hBF},
    {2'd3, 3'd0, 6'h12, 8'h92}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expSeq(input logic [1:0] sel, input logic [2:0] bc,
                                         input logic [7:0] pid, output int n);
    logic [63:0] e;
    int pos;
    e = '0;
    pos = 0;
    for (int i = 0; i < int'(bc) + 8; i++) begin e[pos] = 1'b0; pos++; end
    e[pos] = 1'b1; pos++;
    for (int f = 0; f < 2; f++) begin
      if ((f == 0 && sel != 2'd0) || (f == 1 && sel[1])) begin
        logic [7:0] b;
        b = (f == 0) ? 8'h55 : pid;
        e[pos] = 1'b0; pos++;
        for (int k = 0; k < 8; k++) begin e[pos] = b[k]; pos++; end
        e[pos] = 1'b1; pos++;
      end
    end
    n = pos;
    return e;
  endfunction

  task automatic runHdr(input logic [1:0] sel, input logic [2:0] bc, input logic [5:0] id,
                        input int gap, input int glitchBit, input bit midGlitch,
                        input bit retrig, output logic [63:0] got, output int ticks);
    int idx;
    bit tickNow;
    got = '0;
    ticks = -1;
    idx = 0;
    @(negedge clk);
    hdrSel = sel; brkCnt = bc; ident = id; trigSet = 1'b1; baudTick = 1'b0; corrupt = 1'b0;
    @(negedge clk);
    trigSet = 1'b0;
    check(busy && !txOut, "R2 start busy/txOut", {busy, txOut}, 2'b10);
    for (int cyc = 0; cyc < 8000; cyc++) begin
      tickNow = (cyc % gap) == 0;
      baudTick = tickNow;
      if (glitchBit >= 0 && idx / 16 == glitchBit)
        corrupt = midGlitch ? 1'b1 : (idx % 16 >= 1 && idx % 16 <= 3);
      else
        corrupt = 1'b0;
      if (retrig && idx >= 40 && idx < 42) begin
        trigSet = 1'b1; hdrSel = ~sel; brkCnt = ~bc; ident = ~id;
      end else begin
        trigSet = 1'b0;
      end
      @(negedge clk);
      if (tickNow) begin
        idx++;
        if (idx % 16 == 8) got[idx / 16] = txOut;
      end
      if (!busy) begin
        ticks = idx;
        break;
      end
    end
    corrupt = 1'b0; trigSet = 1'b0; baudTick = 1'b0;
  endtask

  task automatic pulseDoneClr();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycCount++;
    if (cycCount > 150000) begin
      nFail++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=150000", cycCount);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, exp;
    int ticks, n;
    rstN = 1'b0; trigSet = 1'b0; bitErrEn = 1'b1; baudTick = 1'b0; doneClr = 1'b0;
    errClr = 1'b0; corrupt = 1'b0; hdrSel = '0; brkCnt = '0; ident = '0;
    repeat (4) @(negedge clk);
    check(txOut && !busy && !hdrDone && !bitErr, "R1 reset state",
          {txOut, busy, hdrDone, bitErr}, 4'b1000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txOut && !busy && !hdrDone && !bitErr, "R1 after reset",
          {txOut, busy, hdrDone, bitErr}, 4'b1000);

    for (int v = 0; v < 6; v++) begin
      exp = expSeq(VEC[v][18:17], VEC[v][16:14], VEC[v][7:0], n);
      runHdr(VEC[v][18:17], VEC[v][16:14], VEC[v][13:8], 1, -1, 1'b0, 1'b0, got, ticks);
      check(got == exp, "R3 R4 R5 R6 serial pattern", got, exp);
      check(ticks == 16 * n, "R7 header length in ticks", ticks, 16 * n);
      check(hdrDone && txOut, "R7 done flag and idle line", {hdrDone, txOut}, 2'b11);
      check(!bitErr, "R10 clean loopback", bitErr, 0);
      pulseDoneClr();
      check(!hdrDone, "R11 done cleared", hdrDone, 0);
    end

    // sparse ticks: bit time counts ticks, not clocks
    exp = expSeq(2'd1, 3'd2, 8'h00, n);
    runHdr(2'd1, 3'd2, 6'h00, 3, -1, 1'b0, 1'b0, got, ticks);
    check(got == exp, "R3 pattern with sparse ticks", got, exp);
    check(ticks == 16 * n, "R3 length with sparse ticks", ticks, 16 * n);
    pulseDoneClr();

    // retrigger and field changes mid-header
    exp = expSeq(2'd2, 3'd0, 8'h92, n);
    runHdr(2'd2, 3'd0, 6'h12, 1, -1, 1'b0, 1'b1, got, ticks);
    check(got == exp, "R8 header unchanged by retrigger", got, exp);
    repeat (20) @(negedge clk);
    check(!busy && txOut, "R8 retrigger not queued", {busy, txOut}, 2'b01);
    pulseDoneClr();

    // glitch only early in a bit: ignored
    bitErrEn = 1'b1;
    runHdr(2'd1, 3'd0, 6'h00, 1, 2, 1'b0, 1'b0, got, ticks);
    check(!bitErr, "R10 off-midpoint glitch ignored", bitErr, 0);
    pulseDoneClr();

    // full-bit mismatch with checking disabled
    bitErrEn = 1'b0;
    runHdr(2'd1, 3'd0, 6'h00, 1, 9, 1'b1, 1'b0, got, ticks);
    check(!bitErr, "R10 disabled check ignored", bitErr, 0);
    pulseDoneClr();

    // mismatch while idle
    bitErrEn = 1'b1;
    @(negedge clk); corrupt = 1'b1; baudTick = 1'b1;
    repeat (40) @(negedge clk);
    corrupt = 1'b0; baudTick = 1'b0;
    check(!bitErr && txOut, "R10 idle mismatch ignored", {bitErr, txOut}, 2'b01);

    // mid-bit mismatch sets a sticky flag
    runHdr(2'd0, 3'd0, 6'h00, 1, 3, 1'b1, 1'b0, got, ticks);
    check(bitErr, "R9 mid-bit mismatch flagged", bitErr, 1);
    pulseDoneClr();
    runHdr(2'd0, 3'd1, 6'h00, 1, -1, 1'b0, 1'b0, got, ticks);
    check(bitErr, "R9 flag sticky over clean header", bitErr, 1);
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    check(!bitErr, "R11 error cleared", bitErr, 0);
    check(hdrDone, "R11 done untouched by error clear", hdrDone, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule